// File: doc/BRIEF.md
# Registered Four-Bit Select-Coded ALU

This block is a small arithmetic and logic unit that combines two operands, a carry-in and a three-bit operation code into one result word and one carry bit. Both outputs are captured in flip-flops, so a new operation is applied in one cycle and its outcome appears after the next rising clock edge. The operand width defaults to four bits and is a parameter.

The top code bit splits the block into two halves. When it is low, the block adds. A conditioning stage first chooses the second adder input: zero, the b operand, the inverse of b, or all ones. A ripple chain of full-adder cells then adds that value to a, together with the carry-in. The four arithmetic codes, each used with both carry-in values, cover transfer, increment, addition, addition with carry, subtraction, subtraction less one, decrement and a second form of transfer. When the top code bit is high, a bitwise logic unit produces the result, the carry-in has no effect and the carry-out is zero. An active-low asynchronous reset clears both registered outputs.

Top module: `selcode_alu_reg`

## Requirements
- R1: Code 000 yields result = a + carry_in, meaning transfer of a when carry_in=0 and increment when carry_in=1; carry_out is bit W of that (W+1)-bit sum.
- R2: Code 001 yields {carry_out, result} = a + b + carry_in as a (W+1)-bit sum.
- R3: Code 010 yields {carry_out, result} = a + (~b) + carry_in, so carry_in=1 gives a - b, with carry_out=1 exactly when no borrow occurs (a >= b).
- R4: Code 011 yields {carry_out, result} = a + all-ones + carry_in, so carry_in=0 gives a - 1 (carry_out=1 unless a=0) and carry_in=1 gives a with carry_out=1.
- R5: Codes 100, 101, 110 and 111 yield a OR b, a XOR b, a AND b and NOT a respectively.
- R6: For codes 100 to 111 the carry_in value has no effect on the result, and carry_out is 0.
- R7: result and carry_out change only on a rising clock edge and reflect the inputs present just before that edge; input changes between edges leave them unchanged.
- R8: A low rst_n clears result and carry_out to 0 at once, with no clock edge needed, and holds them at 0 while it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs are captured on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into the adder; ignored by logic codes |
| op_sel | input | 3 | Operation code; bit 2 high selects the logic unit |
| result | output | W | Registered result word |
| carry_out | output | 1 | Registered carry from the adder; 0 for logic codes |

## Verification
The bench sweeps every operand pair under every code and both carry-in values, so each arithmetic code is checked at its wrap points: increment of all ones, decrement of zero, and subtraction with equal operands or a borrow. A conditioning stage that put the wrong constant on the adder input would show up as an off-by-one result on decrement or transfer, and a wrong carry-in wiring would break the pairs of codes that differ only in carry-in. Logic codes are run with both carry-in values to catch a carry that leaks into the logic result or a carry_out that is not forced to zero. Timing is checked by changing inputs in mid-cycle and by asserting reset between edges, which catches a combinational output path or a reset that waits for the clock.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   typedef enum logic [2:0] {
      OP_PASS = 3'b000,
      OP_ADD  = 3'b001,
      OP_SUB  = 3'b010,
      OP_DEC  = 3'b011,
      OP_OR   = 3'b100,
      OP_XOR  = 3'b101,
      OP_AND  = 3'b110,
      OP_INV  = 3'b111
   } op_e;

   localparam int unsigned OP_W = 3;

   function automatic logic op_is_logic(input op_e op);
      return op[OP_W-1];
   endfunction

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic prop;
   logic gen;

   always_comb begin
      prop = x ^ y;
      gen  = x & y;
      s    = prop ^ ci;
      co   = gen | (prop & ci);
   end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] sum,
   output logic         co
);
   localparam int unsigned NCARRY = W + 1;

   logic [NCARRY-1:0] chain;

   if (W < 1) begin : g_bad_width
      $error("alu_ripple_add: W must be at least 1");
   end

   assign chain[0] = ci;

   for (genvar i = 0; i < W; i++) begin : g_stage
      alu_fa_cell u_cell (
         .x  (x[i]),
         .y  (y[i]),
         .ci (chain[i]),
         .s  (sum[i]),
         .co (chain[i+1])
      );
   end

   assign co = chain[NCARRY-1];
endmodule

// File: rtl/alu_bmux.sv
module alu_bmux
   import alu4_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [OP_W-2:0] mode,
   input  logic [W-1:0]    b_in,
   output logic [W-1:0]    b_out
);
   localparam logic [W-1:0] ZEROS = '0;
   localparam logic [W-1:0] ONES  = '1;

   if (W < 1) begin : g_bad_width
      $error("alu_bmux: W must be at least 1");
   end

   always_comb begin
      unique case (mode)
         2'b00:   b_out = ZEROS;
         2'b01:   b_out = b_in;
         2'b10:   b_out = ~b_in;
         default: b_out = ONES;
      endcase
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu4_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [OP_W-2:0] mode,
   input  logic [W-1:0]    x,
   input  logic [W-1:0]    y,
   output logic [W-1:0]    z
);
   if (W < 1) begin : g_bad_width
      $error("alu_logic: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         unique case (mode)
            2'b00:   z[i] = x[i] | y[i];
            2'b01:   z[i] = x[i] ^ y[i];
            2'b10:   z[i] = x[i] & y[i];
            default: z[i] = ~x[i];
         endcase
      end
   end
endmodule

// File: rtl/selcode_alu_reg.sv
module selcode_alu_reg
   import alu4_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   input  logic             carry_in,
   input  logic [OP_W-1:0]  op_sel,
   output logic [W-1:0]     result,
   output logic             carry_out
);
   localparam int unsigned SW = W + 1;

   if (W < 1) begin : g_bad_width
      $error("selcode_alu_reg: W must be at least 1");
   end

   op_e          op;
   logic         logic_mode;
   logic [W-1:0] b_cond;
   logic [W-1:0] add_sum;
   logic         add_co;
   logic [W-1:0] log_res;
   logic [W-1:0] nxt_res;
   logic         nxt_co;

   assign op         = op_e'(op_sel);
   assign logic_mode = op_is_logic(op);

   alu_bmux #(.W(W)) u_bmux (
      .mode  (op_sel[OP_W-2:0]),
      .b_in  (op_b),
      .b_out (b_cond)
   );

   alu_ripple_add #(.W(W)) u_add (
      .x   (op_a),
      .y   (b_cond),
      .ci  (carry_in),
      .sum (add_sum),
      .co  (add_co)
   );

   alu_logic #(.W(W)) u_logic (
      .mode (op_sel[OP_W-2:0]),
      .x    (op_a),
      .y    (op_b),
      .z    (log_res)
   );

   always_comb begin
      if (logic_mode) begin
         nxt_res = log_res;
         nxt_co  = 1'b0;
      end else begin
         nxt_res = add_sum;
         nxt_co  = add_co;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         carry_out <= 1'b0;
      end else begin
         result    <= nxt_res;
         carry_out <= nxt_co;
      end
   end

   // checker state: set after the first edge out of reset
   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   // R8
   rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (result == '0) && !carry_out);

   // R6
   logic_cout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && $past(op_sel[OP_W-1])) |-> !carry_out);

   // R5
   invert_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && $past(op_sel) == 3'b111) |-> result == ~$past(op_a));

   // R1
   transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && $past(op_sel) == 3'b000 && !$past(carry_in))
         |-> (result == $past(op_a)) && !carry_out);

   // R2
   add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && $past(op_sel) == 3'b001)
         |-> {carry_out, result} ==
             ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + SW'($past(carry_in))));
endmodule

// File: tb/selcode_alu_reg_tb.sv
`timescale 1ns/1ps
module selcode_alu_reg_tb;
   localparam int W = 4;
   localparam int N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [2:0]   op_sel = 3'b000;
   logic [W-1:0] result;
   logic         carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   selcode_alu_reg #(.W(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .op_sel    (op_sel),
      .result    (result),
      .carry_out (carry_out)
   );

   function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [2:0] s, input logic c);
      logic [W:0] ci;
      ci = {{W{1'b0}}, c};
      case (s)
         3'b000:  return {1'b0, a} + ci;
         3'b001:  return {1'b0, a} + {1'b0, b} + ci;
         3'b010:  return {1'b0, a} + {1'b0, ~b} + ci;
         3'b011:  return {1'b0, a} + {1'b0, {W{1'b1}}} + ci;
         3'b100:  return {1'b0, a | b};
         3'b101:  return {1'b0, a ^ b};
         3'b110:  return {1'b0, a & b};
         default: return {1'b0, ~a};
      endcase
   endfunction

   task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got cout=%b f=%h, expected cout=%b f=%h",
                  req, act[W], act[W-1:0], exp[W], exp[W-1:0]);
      end
   endtask

   task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] s, input logic c);
      @(negedge clk);
      op_a = a; op_b = b; op_sel = s; carry_in = c;
      @(posedge clk);
      #2;
      check(req, {carry_out, result}, model(a, b, s, c));
   endtask

   task automatic sweep_code(input string req, input logic [2:0] s);
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
               apply(req, W'(a), W'(b), s, 1'(c));
   endtask

   // R8: state while reset is held from time zero
   task automatic test_reset_state();
      #35;
      check("R8", {carry_out, result}, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1: transfer and increment, including wrap of all ones
   task automatic test_pass_inc();
      sweep_code("R1", 3'b000);
   endtask

   // R2: addition with and without carry
   task automatic test_add();
      sweep_code("R2", 3'b001);
   endtask

   // R3: subtraction forms, borrow on a < b
   task automatic test_sub();
      sweep_code("R3", 3'b010);
   endtask

   // R4: decrement (wraps at zero) and transfer with carry_out=1
   task automatic test_dec();
      sweep_code("R4", 3'b011);
   endtask

   // R5, R6: logic codes with both carry_in values
   task automatic test_logic();
      for (int s = 4; s < 8; s++) begin
         sweep_code("R5", 3'(s));
      end
      for (int a = 0; a < N; a++) begin
         apply("R6", W'(a), W'(N - 1 - a), 3'b101, 1'b1);
         check("R6", {carry_out, result}, {1'b0, W'(a) ^ W'(N - 1 - a)});
      end
   endtask

   // R7: mid-cycle input change does not reach outputs before the edge
   task automatic test_timing();
      logic [W:0] held;
      apply("R7", 4'h9, 4'h3, 3'b001, 1'b0);
      held = {carry_out, result};
      @(negedge clk);
      op_a = 4'hF; op_b = 4'hF; op_sel = 3'b001; carry_in = 1'b1;
      #5;
      check("R7", {carry_out, result}, held);
      @(posedge clk);
      #2;
      check("R7", {carry_out, result}, model(4'hF, 4'hF, 3'b001, 1'b1));
   endtask

   // R8: asynchronous clear between edges, hold, then resume
   task automatic test_async_reset();
      apply("R8", 4'hF, 4'h1, 3'b001, 1'b1);
      check("R8", {carry_out, result}, 5'h11);
      #3;
      rst_n = 1'b0;
      #1;
      check("R8", {carry_out, result}, '0);
      @(posedge clk);
      #2;
      check("R8", {carry_out, result}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      apply("R8", 4'h7, 4'h8, 3'b100, 1'b0);
   endtask

   initial begin
      test_reset_state();
      test_pass_inc();
      test_add();
      test_sub();
      test_dec();
      test_logic();
      test_timing();
      test_async_reset();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule